// File: doc/BRIEF.md
# Fuse-Map Sum-of-Products Logic Array

This block models a small programmable sum-of-products device. Eleven logic inputs feed three outputs. Each output has four product terms of its own. A product term can take the true form, the complemented form, both or neither of every input. A map of configuration bits with fuse semantics decides which literals each term uses. A set bit is an intact fuse and keeps its literal in the AND. A cleared bit is a blown fuse and makes its literal read as 1. Each output is the NOR of its four terms, so a written equation `Y' = t0 + t1 + t2 + t3` is realised directly. The path from `pin_in` to `pin_out` is purely combinational.

The map is configured through a synchronous port. An erase pulse, and also reset, sets every fuse to intact. A serial port shifts in one fuse per clock while its enable is high. A readback port returns any stored fuse combinationally. No shadow copy of the map is kept, so the outputs follow the map as it is being written.

A loader state machine controls the serial port. Its states are `ST_IDLE`, `ST_LOAD`, `ST_FULL` and `ST_DONE`:
- **start** (`ST_IDLE` or `ST_DONE` to `ST_LOAD`): the enable is high. The machine writes index 0 and points at index 1.
- **pause** (`ST_LOAD` to `ST_IDLE`): the enable drops before the map is full.
- **fill** (`ST_LOAD` to `ST_FULL`): the last index is written.
- **release** (`ST_FULL` to `ST_DONE`): the enable drops.
- **wipe** (any state to `ST_IDLE`): an erase arrives.

While the machine stays in `ST_FULL` with the enable still high, every extra bit is ignored.

Top module: `pal_emu`

## Requirements
- R1: After reset every fuse reads 1, `ld_done` is 0 and `pin_out` is all ones, because every product term evaluates to 0.
- R2: The fuse for output o, term t, input i and polarity p sits at index ((o*4+t)*11+i)*2+p. Here p=0 is the true literal, p=1 is the complemented literal, and input i is `pin_in[i]`.
- R3: A one-cycle `erase` sets all 264 fuses to 1 and clears `ld_done`. It also returns the loader to index 0 and takes priority over a load in the same cycle.
- R4: A product term is the AND of the literals whose fuse is 1. A term whose fuses are all 0 evaluates to 1 and forces its output to 0.
- R5: `pin_out[o]` is the NOR of output o's own four terms. Fuses of one output never affect another output.
- R6: While `ld_en` is high, `ld_bit` is written at one index per clock. Every new assertion of `ld_en` starts again at index 0, including one after a pause.
- R7: `ld_done` goes to 1 on the clock that writes index 263. It stays at 1 until an erase or a new load starts. Bits presented while `ld_en` stays high after that are ignored.
- R8: `rd_bit` returns fuse `rd_idx` combinationally. Indices 264 and above read 0.
- R9: During a load, `pin_out` follows the partly written map at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; erases the map |
| erase | input | 1 | One-cycle erase command |
| ld_en | input | 1 | Serial load enable |
| ld_bit | input | 1 | Fuse value to write (1 = intact) |
| rd_idx | input | 9 | Readback fuse index |
| rd_bit | output | 1 | Fuse value at `rd_idx`, or 0 if out of range |
| ld_done | output | 1 | High once all 264 fuses are loaded |
| pin_in | input | 11 | Logic inputs; bit 0 is the first input |
| pin_out | output | 3 | NOR-of-terms outputs |

## Verification
The bench aims at the edges of the loader. It checks the flag on the 263rd and the 264th bit. A design that is off by one here raises `ld_done` a cycle early or late. It also checks bits held after the map is full: a design that wraps the index would overwrite fuse 0. Two more checks cover a restart after a pause, which would continue from the old index if wrong, and an erase in the middle of a load, which would leave written zeros behind if it lost priority. Logic checks place single literals at computed indices. They also test a fully blown term and untouched terms, which catches polarity or index swaps, and a map that leaks between outputs. Random traffic is compared against a behavioural model on every clock.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int DEF_N_IN  = 11;
    localparam int DEF_N_OUT = 3;
    localparam int DEF_N_PT  = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_FULL = 2'd2,
        ST_DONE = 2'd3
    } ld_state_t;
endpackage

// File: rtl/pal_cfg.sv
module pal_cfg
    import pal_pkg::*;
#(
    parameter int N_FUSE = 264,
    parameter int IDX_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              ld_en,
    input  logic              ld_bit,
    output logic [N_FUSE-1:0] fuse_map,
    output logic              ld_done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_FUSE - 1);
    localparam logic [IDX_W-1:0] ONE_IDX  = IDX_W'(1);

    ld_state_t        st_q, st_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            ptr_q <= '0;
        end else begin
            st_q  <= st_d;
            ptr_q <= ptr_d;
        end
    end

    // next state and write control
    always_comb begin
        st_d   = st_q;
        ptr_d  = ptr_q;
        wr_en  = 1'b0;
        wr_idx = ptr_q;
        if (erase) begin
            st_d  = ST_IDLE;
            ptr_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_DONE: begin
                    if (ld_en) begin
                        wr_en  = 1'b1;
                        wr_idx = '0;
                        ptr_d  = ONE_IDX;
                        st_d   = ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (ld_en) begin
                        wr_en = 1'b1;
                        if (ptr_q == LAST_IDX) begin
                            st_d  = ST_FULL;
                            ptr_d = '0;
                        end else begin
                            ptr_d = ptr_q + ONE_IDX;
                        end
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
                ST_FULL: begin
                    if (!ld_en) st_d = ST_DONE;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        ld_done = (st_q == ST_FULL) || (st_q == ST_DONE);
    end

    // fuse storage, intact (1) after reset or erase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fuse_map <= '1;
        end else if (erase) begin
            fuse_map <= '1;
        end else if (wr_en) begin
            fuse_map[wr_idx] <= ld_bit;
        end
    end
endmodule

// File: rtl/pal_term.sv
module pal_term #(
    parameter int N_IN = 11
) (
    input  logic [N_IN-1:0]   x,
    input  logic [2*N_IN-1:0] fuses,
    output logic              term
);
    logic [N_IN-1:0] lit_ok;

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        // an intact fuse keeps its literal, a blown one reads as 1
        assign lit_ok[i] = (~fuses[2*i] | x[i]) & (~fuses[2*i+1] | ~x[i]);
    end

    assign term = &lit_ok;
endmodule

// File: rtl/pal_nor.sv
module pal_nor #(
    parameter int N_PT = 4
) (
    input  logic [N_PT-1:0] terms,
    output logic            y
);
    assign y = ~|terms;
endmodule

// File: rtl/pal_emu.sv
module pal_emu
    import pal_pkg::*;
#(
    parameter  int N_IN   = DEF_N_IN,
    parameter  int N_OUT  = DEF_N_OUT,
    parameter  int N_PT   = DEF_N_PT,
    localparam int LIT    = 2 * N_IN,
    localparam int N_FUSE = N_OUT * N_PT * LIT,
    localparam int IDX_W  = $clog2(N_FUSE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             erase,
    input  logic             ld_en,
    input  logic             ld_bit,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit,
    output logic             ld_done,
    input  logic [N_IN-1:0]  pin_in,
    output logic [N_OUT-1:0] pin_out
);
    logic [N_FUSE-1:0] fuse_map;

    pal_cfg #(
        .N_FUSE(N_FUSE),
        .IDX_W (IDX_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .erase   (erase),
        .ld_en   (ld_en),
        .ld_bit  (ld_bit),
        .fuse_map(fuse_map),
        .ld_done (ld_done)
    );

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [N_PT-1:0] terms;
        for (genvar t = 0; t < N_PT; t++) begin : g_pt
            pal_term #(.N_IN(N_IN)) u_term (
                .x    (pin_in),
                .fuses(fuse_map[(o*N_PT+t)*LIT +: LIT]),
                .term (terms[t])
            );
        end
        pal_nor #(.N_PT(N_PT)) u_nor (
            .terms(terms),
            .y    (pin_out[o])
        );
    end

    always_comb begin
        rd_bit = 1'b0;
        if (rd_idx < IDX_W'(N_FUSE)) rd_bit = fuse_map[rd_idx];
    end
endmodule

// File: rtl/pal_emu_chk.sv
module pal_emu_chk #(
    parameter int N_OUT  = 3,
    parameter int N_FUSE = 264,
    parameter int IDX_W  = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             erase,
    input logic             ld_en,
    input logic [IDX_W-1:0] rd_idx,
    input logic             rd_bit,
    input logic             ld_done,
    input logic [N_OUT-1:0] pin_out
);
    a_r3_erase_outputs_high: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (&pin_out));

    a_r3_erase_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> !ld_done);

    a_r7_done_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ld_done) |-> ($past(ld_en) && !$past(erase)));

    a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ld_done) |-> ($past(erase) || $past(ld_en)));

    a_r8_out_of_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx >= IDX_W'(N_FUSE)) |-> !rd_bit);
endmodule

bind pal_emu pal_emu_chk #(
    .N_OUT (N_OUT),
    .N_FUSE(N_FUSE),
    .IDX_W (IDX_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .erase  (erase),
    .ld_en  (ld_en),
    .rd_idx (rd_idx),
    .rd_bit (rd_bit),
    .ld_done(ld_done),
    .pin_out(pin_out)
);

// File: tb/test_pal_emu.sv
module test_pal_emu;
    localparam int NF = 264;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       erase = 1'b0;
    logic       ld_en = 1'b0;
    logic       ld_bit = 1'b0;
    logic [8:0] rd_idx = '0;
    logic       rd_bit;
    logic       ld_done;
    logic [10:0] pin_in = '0;
    logic [2:0] pin_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    bit cmp_on = 0;

    // behavioural model
    bit m_map [NF];
    int m_ptr = 0;
    bit m_done = 0;
    bit m_active = 0;

    always #10 clk = ~clk;

    pal_emu i_pal_emu (
        .clk(clk), .rst_n(rst_n), .erase(erase), .ld_en(ld_en), .ld_bit(ld_bit),
        .rd_idx(rd_idx), .rd_bit(rd_bit), .ld_done(ld_done),
        .pin_in(pin_in), .pin_out(pin_out)
    );

    function automatic int fidx(int o, int t, int i, int p);
        return ((o * 4 + t) * 11 + i) * 2 + p;
    endfunction

    task automatic m_wipe();
        for (int k = 0; k < NF; k++) m_map[k] = 1'b1;
        m_ptr = 0; m_done = 0; m_active = 0;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || erase) begin
            m_wipe();
        end else if (ld_en) begin
            if (!m_active) begin
                m_ptr = 0; m_done = 0; m_active = 1;
            end
            if (m_ptr < NF) begin
                m_map[m_ptr] = ld_bit;
                m_ptr++;
                if (m_ptr == NF) m_done = 1;
            end
        end else begin
            m_active = 0;
        end
    end

    function automatic logic [2:0] m_out(logic [10:0] x);
        logic [2:0] r;
        for (int o = 0; o < 3; o++) begin
            bit any = 0;
            for (int t = 0; t < 4; t++) begin
                bit tv = 1;
                for (int i = 0; i < 11; i++) begin
                    if (m_map[fidx(o, t, i, 0)] && !x[i]) tv = 0;
                    if (m_map[fidx(o, t, i, 1)] && x[i]) tv = 0;
                end
                if (tv) any = 1;
            end
            r[o] = !any;
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R7 model ld_done", 32'(ld_done), 32'(m_done));
            chk("R8 model rd_bit", 32'(rd_bit), (rd_idx < NF) ? 32'(m_map[rd_idx]) : 32'd0);
            chk("R5 model pin_out", 32'(pin_out), 32'(m_out(pin_in)));
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic load_bits(logic [NF-1:0] m, int n);
        for (int k = 0; k < n; k++) begin
            ld_en = 1'b1; ld_bit = m[k];
            step();
        end
        ld_en = 1'b0;
    endtask

    task automatic do_erase();
        erase = 1'b1; step(); erase = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        logic [NF-1:0] m;
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        rd_idx = 9'd0; #2;
        chk("R1 reset pin_out", 32'(pin_out), 32'h7);
        chk("R1 reset rd_bit", 32'(rd_bit), 32'd1);
        chk("R1 reset ld_done", 32'(ld_done), 32'd0);
        cmp_on = 1;

        // R2 R4 R5: out0 = NOR(D, J'), out1 term0 fully blown, out2 untouched
        m = '1;
        for (int i = 0; i < 22; i++) begin
            m[fidx(0, 0, 0, 0) + i] = 1'b0;
            m[fidx(0, 1, 0, 0) + i] = 1'b0;
            m[fidx(1, 0, 0, 0) + i] = 1'b0;
        end
        m[fidx(0, 0, 3, 0)] = 1'b1;
        m[fidx(0, 1, 9, 1)] = 1'b1;
        load_bits(m, NF - 1);
        #2 chk("R7 done low after 263 bits", 32'(ld_done), 32'd0);
        load_bits(m >> (NF - 1), 1);
        #2 chk("R7 done high after 264 bits", 32'(ld_done), 32'd1);
        pin_in = 11'b010_0000_0000; #2;
        chk("R2 R4 D=0 J=1", 32'(pin_out), 32'b101);
        pin_in = 11'b010_0000_1000; #2;
        chk("R2 R5 D=1 J=1", 32'(pin_out), 32'b100);
        pin_in = 11'b000_0000_0000; #2;
        chk("R2 R5 D=0 J=0", 32'(pin_out), 32'b100);
        rd_idx = 9'(fidx(0, 1, 9, 1)); #2;
        chk("R8 readback intact", 32'(rd_bit), 32'd1);
        rd_idx = 9'd300; #2;
        chk("R8 out of range", 32'(rd_bit), 32'd0);

        // R7 bits held after full are ignored
        ld_en = 1'b1; ld_bit = 1'b1;
        step(); step(); step();
        ld_en = 1'b0; step();
        rd_idx = 9'd0; #2;
        chk("R7 extra bits ignored", 32'(rd_bit), 32'd0);
        chk("R7 done persists", 32'(ld_done), 32'd1);

        // R9 partial map, R6 restart
        do_erase();
        #2 chk("R3 erase outputs", 32'(pin_out), 32'h7);
        load_bits('0, 22);
        #2 chk("R9 partial map visible", 32'(pin_out), 32'b110);
        step();
        load_bits('1, 1);
        rd_idx = 9'd0; #2;
        chk("R6 restart writes index 0", 32'(rd_bit), 32'd1);
        rd_idx = 9'd1; #2;
        chk("R6 index 1 kept", 32'(rd_bit), 32'd0);
        pin_in = 11'd1; #2;
        chk("R4 term A with A=1", 32'(pin_out), 32'b110);
        pin_in = 11'd0; #2;
        chk("R4 term A with A=0", 32'(pin_out), 32'b111);

        // R3 erase during load wins
        load_bits('0, 5);
        ld_en = 1'b1; ld_bit = 1'b0; erase = 1'b1;
        step();
        ld_en = 1'b0; erase = 1'b0;
        rd_idx = 9'd2; #2;
        chk("R3 erase mid-load", 32'(rd_bit), 32'd1);
        chk("R3 erase done low", 32'(ld_done), 32'd0);

        // random traffic against the model
        for (int c = 0; c < 4000; c++) begin
            erase  = ($urandom_range(0, 199) == 0);
            if ($urandom_range(0, 19) == 0) ld_en = ~ld_en;
            ld_bit = ($urandom_range(0, 3) != 0);
            pin_in = 11'($urandom);
            rd_idx = 9'($urandom_range(0, 300));
            step();
        end
        erase = 1'b0; ld_en = 1'b0;
        step(); step();
        finished = 1;
        report();
        $finish;
    end
endmodule